// File: doc/BRIEF.md
# Store Queue with Youngest-Match Forwarding

This block buffers stores for an out-of-order core in a circular array. Stores are appended at the tail when they are dispatched. A separate retire pointer divides the live entries into two regions. Between head and the retire pointer sit committed stores that have not yet reached memory. Between the retire pointer and the tail sit speculative stores that may still be cancelled. Committed stores leave from the head through a simple memory write port, one per accepted cycle. This can happen any number of cycles after they were committed.

Loads search the queue in the same cycle. The load address is compared against every live entry, and the youngest matching store supplies the data. When nothing matches, the value the load brought from memory passes through unchanged.

A flush cuts the speculative region back to a given slot. It never discards a committed store.

Top module: `store_fwd_queue`

## Requirements
- R1: After reset the queue is empty: `stall_o`, `mem_we_o` and `ld_hit_o` are all low.
- R2: A push accepted while fewer than DEPTH entries are live stores the address and data at the tail slot. The tail then advances by one, with slot indices counting 0 to DEPTH-1 and wrapping.
- R3: `stall_o` is high whenever DEPTH entries are live or `flush_i` is high. A push in such a cycle is dropped and changes no state, so occupancy never exceeds DEPTH.
- R4: `retire_i` commits the oldest speculative store. It is ignored when there is no speculative entry.
- R5: `mem_we_o` is high exactly when at least one committed store is present, and `mem_addr_o`/`mem_data_o` show the head entry. When `mem_ready_i` is also high, the head advances by one, so committed stores leave in program order. Speculative stores are never presented.
- R6: A lookup compares `ld_addr_i` against all live entries, committed ones included. On a hit, `ld_hit_o` is high, `ld_idx_o` is the slot of the youngest matching entry, and `ld_data_o` is that entry's data.
- R7: On a miss, `ld_hit_o` is low and `ld_data_o` equals `ld_mem_data_i`.
- R8: A flush naming a live speculative slot keeps that slot and every older entry, and sets the tail to the slot that follows it.
- R9: A flush naming a committed slot removes all speculative entries and keeps every committed one.
- R10: A flush naming a slot that is not live has no effect.
- R11: In a flush cycle, a drain and a retire still take effect. The flush is judged against the retire pointer as it stands after that cycle's retire.
- R12: All of the above holds across pointer wraparound, with full and empty distinguished by a wrap bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Dispatch a store |
| push_addr_i | input | ADDR_W | Store address |
| push_data_i | input | DATA_W | Store data |
| stall_o | output | 1 | Push refused this cycle |
| retire_i | input | 1 | Commit oldest speculative store |
| flush_i | input | 1 | Truncate speculative region |
| flush_idx_i | input | PTR_W | Last slot kept by the flush |
| mem_ready_i | input | 1 | Memory accepts the presented write |
| mem_we_o | output | 1 | Committed store presented |
| mem_addr_o | output | ADDR_W | Write address |
| mem_data_o | output | DATA_W | Write data |
| ld_addr_i | input | ADDR_W | Load lookup address |
| ld_mem_data_i | input | DATA_W | Load value read from memory |
| ld_hit_o | output | 1 | Lookup matched a live entry |
| ld_idx_o | output | PTR_W | Slot of youngest match |
| ld_data_o | output | DATA_W | Forwarded or memory value |

## Verification
Lookups use only a handful of address values. This keeps duplicates common, so the result shows whether the youngest entry wins or an older one leaks through. Directed sequences fill the queue, push into a full queue, and aim flushes at a committed slot, a speculative slot and an empty slot. Together these separate the clamp to the retire pointer, the normal truncation and the no-op case. A long random run with frequent drains and retires moves the pointers around the ring many times. It also lines flushes up with drains and retires in the same cycle, which exposes wraparound faults in the age priority and the occupancy count.

// File: rtl/sfq_pkg.sv
package sfq_pkg;
  typedef enum logic [1:0] {
    FL_NONE,
    FL_TO_RTR,
    FL_AT_IDX
  } flush_kind_e;
endpackage

// File: rtl/sfq_ptr_ctrl.sv
module sfq_ptr_ctrl #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned PW = PTR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             retire_i,
  input  logic             drain_rdy_i,
  input  logic             flush_i,
  input  logic [PTR_W-1:0] flush_idx_i,
  output logic [PW-1:0]    head_o,
  output logic [PW-1:0]    rtr_o,
  output logic [PW-1:0]    tail_o,
  output logic [PW-1:0]    live_o,
  output logic             full_o,
  output logic             has_ret_o,
  output logic             push_ok_o,
  output logic             drain_o
);
  import sfq_pkg::*;

  logic [PW-1:0] head_q, rtr_q, tail_q;
  logic [PW-1:0] head_d, rtr_d, tail_d;
  logic [PW-1:0] live, ret_cnt, spec_cnt, ret_nxt, flush_dist;
  logic          retire_ok;
  flush_kind_e   fkind;

  assign live       = tail_q - head_q;
  assign ret_cnt    = rtr_q - head_q;
  assign spec_cnt   = tail_q - rtr_q;
  assign full_o     = (live == PW'(DEPTH));
  assign has_ret_o  = (ret_cnt != '0);
  assign drain_o    = has_ret_o & drain_rdy_i;
  assign retire_ok  = retire_i & (spec_cnt != '0);
  assign push_ok_o  = push_i & ~full_o & ~flush_i;
  // distance of the flush slot from the head, in slots
  assign flush_dist = {1'b0, PTR_W'(flush_idx_i - head_q[PTR_W-1:0])};

  always_comb begin
    head_d  = head_q + PW'(drain_o);
    rtr_d   = rtr_q + PW'(retire_ok);
    ret_nxt = rtr_d - head_q;
    fkind   = FL_NONE;
    if (flush_i) begin
      if (flush_dist < ret_nxt)   fkind = FL_TO_RTR;
      else if (flush_dist < live) fkind = FL_AT_IDX;
    end
    tail_d = tail_q;
    unique case (fkind)
      FL_TO_RTR: tail_d = rtr_d;
      FL_AT_IDX: tail_d = head_q + flush_dist + PW'(1);
      default:   if (push_ok_o) tail_d = tail_q + PW'(1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      rtr_q  <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_d;
      rtr_q  <= rtr_d;
      tail_q <= tail_d;
    end
  end

  assign head_o = head_q;
  assign rtr_o  = rtr_q;
  assign tail_o = tail_q;
  assign live_o = live;
endmodule

// File: rtl/sfq_storage.sv
module sfq_storage #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned PW = PTR_W + 1
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  wslot_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PTR_W-1:0]  head_slot_i,
  input  logic [PW-1:0]     live_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  input  logic [PTR_W-1:0]  lk_slot_i,
  output logic [DEPTH-1:0]  hit_vec_o,
  output logic [DATA_W-1:0] lk_data_o,
  output logic [ADDR_W-1:0] hd_addr_o,
  output logic [DATA_W-1:0] hd_data_o
);
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      addr_q[wslot_i] <= waddr_i;
      data_q[wslot_i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [PTR_W-1:0] off;
    logic             live;
    assign off          = PTR_W'(g) - head_slot_i;
    assign live         = ({1'b0, off} < live_i);
    assign hit_vec_o[g] = live & (addr_q[g] == lk_addr_i);
  end

  assign lk_data_o = data_q[lk_slot_i];
  assign hd_addr_o = addr_q[head_slot_i];
  assign hd_data_o = data_q[head_slot_i];
endmodule

// File: rtl/sfq_youngest_sel.sv
module sfq_youngest_sel #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] hit_vec_i,
  input  logic [PTR_W-1:0] tail_slot_i,
  output logic             hit_o,
  output logic [PTR_W-1:0] slot_o
);
  // walk from oldest age to youngest; the last match written wins
  always_comb begin
    hit_o  = 1'b0;
    slot_o = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      logic [PTR_W-1:0] s;
      s = tail_slot_i - PTR_W'(k + 1);
      if (hit_vec_i[s]) begin
        hit_o  = 1'b1;
        slot_o = s;
      end
    end
  end
endmodule

// File: rtl/store_fwd_queue.sv
module store_fwd_queue #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned PW = PTR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic [DATA_W-1:0] push_data_i,
  output logic              stall_o,
  input  logic              retire_i,
  input  logic              flush_i,
  input  logic [PTR_W-1:0]  flush_idx_i,
  input  logic              mem_ready_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [DATA_W-1:0] ld_mem_data_i,
  output logic              ld_hit_o,
  output logic [PTR_W-1:0]  ld_idx_o,
  output logic [DATA_W-1:0] ld_data_o
);
  logic [PW-1:0]     head, rtr, tail, live;
  logic              full, has_ret, push_ok, drain;
  logic [DEPTH-1:0]  hit_vec;
  logic              sel_hit;
  logic [PTR_W-1:0]  sel_slot;
  logic [DATA_W-1:0] fwd_data;

  sfq_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push_i),
    .retire_i    (retire_i),
    .drain_rdy_i (mem_ready_i),
    .flush_i     (flush_i),
    .flush_idx_i (flush_idx_i),
    .head_o      (head),
    .rtr_o       (rtr),
    .tail_o      (tail),
    .live_o      (live),
    .full_o      (full),
    .has_ret_o   (has_ret),
    .push_ok_o   (push_ok),
    .drain_o     (drain)
  );

  sfq_storage #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i       (clk_i),
    .we_i        (push_ok),
    .wslot_i     (tail[PTR_W-1:0]),
    .waddr_i     (push_addr_i),
    .wdata_i     (push_data_i),
    .head_slot_i (head[PTR_W-1:0]),
    .live_i      (live),
    .lk_addr_i   (ld_addr_i),
    .lk_slot_i   (sel_slot),
    .hit_vec_o   (hit_vec),
    .lk_data_o   (fwd_data),
    .hd_addr_o   (mem_addr_o),
    .hd_data_o   (mem_data_o)
  );

  sfq_youngest_sel #(.DEPTH(DEPTH)) u_sel (
    .hit_vec_i   (hit_vec),
    .tail_slot_i (tail[PTR_W-1:0]),
    .hit_o       (sel_hit),
    .slot_o      (sel_slot)
  );

  assign stall_o   = full | flush_i;
  assign mem_we_o  = has_ret;
  assign ld_hit_o  = sel_hit;
  assign ld_idx_o  = sel_slot;
  assign ld_data_o = sel_hit ? fwd_data : ld_mem_data_i;
endmodule

// File: rtl/store_fwd_queue_chk.sv
module store_fwd_queue_chk #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned PW = PTR_W + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [PW-1:0] head_i,
  input logic [PW-1:0] rtr_i,
  input logic [PW-1:0] tail_i,
  input logic          push_i,
  input logic          flush_i,
  input logic          stall_o,
  input logic          mem_we_o,
  input logic          mem_ready_i,
  input logic          ld_hit_o
);
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    PW'(tail_i - head_i) <= PW'(DEPTH));

  p_rtr_inside_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    PW'(rtr_i - head_i) <= PW'(tail_i - head_i));

  p_refused_push_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && stall_o && !flush_i |=> tail_i == $past(tail_i));

  p_drain_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && mem_ready_i |=> head_i == PW'($past(head_i) + PW'(1)));

  p_no_drain_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_o |=> head_i == $past(head_i));

  p_flush_keeps_retired_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> PW'(tail_i - $past(head_i)) >= PW'($past(rtr_i) - $past(head_i)));

  p_hit_needs_live_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_hit_o |-> tail_i != head_i);
endmodule

bind store_fwd_queue store_fwd_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .head_i      (head),
  .rtr_i       (rtr),
  .tail_i      (tail),
  .push_i      (push_i),
  .flush_i     (flush_i),
  .stall_o     (stall_o),
  .mem_we_o    (mem_we_o),
  .mem_ready_i (mem_ready_i),
  .ld_hit_o    (ld_hit_o)
);

// File: tb/store_fwd_queue_tb.sv
`timescale 1ns/1ps
module store_fwd_queue_tb;
  localparam int D = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push, retire, flush, rdy;
  logic [15:0] paddr, laddr;
  logic [31:0] pdata, lmem;
  logic [2:0]  fidx;
  logic        stall, we, hit;
  logic [15:0] maddr;
  logic [31:0] mdata, ldata;
  logic [2:0]  lidx;

  int n_cmp = 0, n_err = 0;
  bit done = 0;

  int          m_head = 0, m_rtr = 0, m_tail = 0;
  logic [15:0] m_addr [D];
  logic [31:0] m_data [D];

  always #2 clk = ~clk;

  store_fwd_queue #(.DEPTH(D), .ADDR_W(16), .DATA_W(32)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .push_i(push), .push_addr_i(paddr), .push_data_i(pdata), .stall_o(stall),
    .retire_i(retire), .flush_i(flush), .flush_idx_i(fidx),
    .mem_ready_i(rdy), .mem_we_o(we), .mem_addr_o(maddr), .mem_data_o(mdata),
    .ld_addr_i(laddr), .ld_mem_data_i(lmem),
    .ld_hit_o(hit), .ld_idx_o(lidx), .ld_data_o(ldata)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input bit p, input logic [15:0] pa, input bit r,
                     input bit rd, input bit f, input logic [2:0] fi, input logic [15:0] la);
    int cnt, nh, nr, nt, d;
    bit e_we, e_hit;
    logic [2:0]  e_idx;
    logic [31:0] e_data;
    @(negedge clk);
    push = p; paddr = pa; pdata = $urandom; retire = r; rdy = rd;
    flush = f; fidx = fi; laddr = la; lmem = $urandom;
    #1;
    cnt  = m_tail - m_head;
    e_we = (m_rtr > m_head);
    chk(tag, "stall_o", stall, (cnt == D) || f);
    chk(tag, "mem_we_o", we, e_we);
    if (e_we) begin
      chk(tag, "mem_addr_o", maddr, m_addr[m_head % D]);
      chk(tag, "mem_data_o", mdata, m_data[m_head % D]);
    end
    e_hit = 0; e_idx = '0; e_data = lmem;
    for (int k = 0; k < cnt; k++) begin
      if (!e_hit && m_addr[(m_tail - 1 - k) % D] == la) begin
        e_hit  = 1;
        e_idx  = 3'((m_tail - 1 - k) % D);
        e_data = m_data[e_idx];
      end
    end
    chk(tag, "ld_hit_o", hit, e_hit);
    if (e_hit) chk(tag, "ld_idx_o", lidx, e_idx);
    chk(tag, "ld_data_o", ldata, e_data);
    nh = m_head + ((e_we && rd) ? 1 : 0);
    nr = m_rtr + ((r && m_rtr < m_tail) ? 1 : 0);
    nt = m_tail;
    if (f) begin
      d = (int'(fi) - (m_head % D) + D) % D;
      if (d < nr - m_head)  nt = nr;
      else if (d < cnt)     nt = m_head + d + 1;
    end else if (p && cnt < D) begin
      m_addr[m_tail % D] = pa;
      m_data[m_tail % D] = pdata;
      nt = m_tail + 1;
    end
    m_head = nh; m_rtr = nr; m_tail = nt;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_err++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    push = 0; retire = 0; flush = 0; rdy = 0; paddr = '0; pdata = '0;
    laddr = '0; lmem = '0; fidx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "stall_o", stall, 0);
    chk("R1", "mem_we_o", we, 0);
    chk("R1", "ld_hit_o", hit, 0);
    // fill with duplicate addresses
    for (int i = 0; i < D; i++) cyc("R2", 1, 16'(i % 3), 0, 0, 0, 0, 16'(i % 3));
    cyc("R3", 1, 16'h9, 0, 0, 0, 0, 16'h9);
    cyc("R6", 0, 0, 0, 0, 0, 0, 16'h1);
    cyc("R7", 0, 0, 0, 0, 0, 0, 16'h7);
    for (int i = 0; i < 3; i++) cyc("R4", 0, 0, 1, 0, 0, 0, 16'h2);
    cyc("R9", 0, 0, 0, 0, 1, 3'd1, 16'h0);
    cyc("R9", 0, 0, 0, 0, 0, 0, 16'h1);
    cyc("R2", 1, 16'h5, 0, 0, 0, 0, 16'h5);
    cyc("R2", 1, 16'h6, 0, 0, 0, 0, 16'h6);
    cyc("R10", 0, 0, 0, 0, 1, 3'd7, 16'h6);
    cyc("R10", 0, 0, 0, 0, 0, 0, 16'h6);
    cyc("R8", 0, 0, 0, 0, 1, 3'd3, 16'h6);
    cyc("R8", 0, 0, 0, 0, 0, 0, 16'h6);
    cyc("R11", 1, 16'h3, 1, 1, 1, 3'd3, 16'h5);
    cyc("R11", 0, 0, 1, 0, 0, 0, 16'h5);
    cyc("R4", 0, 0, 1, 0, 0, 0, 16'h5);
    for (int i = 0; i < 6; i++) cyc("R5", 0, 0, 0, 1, 0, 0, 16'h0);
    for (int i = 0; i < 4000; i++)
      cyc("R12", ($urandom % 10) < 6, 16'($urandom % 4), ($urandom % 10) < 4,
          ($urandom % 10) < 3, ($urandom % 20) == 0, 3'($urandom), 16'($urandom % 5));
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule